// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state without software. A single start pulse sets it running. It steps through an ordered list of commands, one list per memory family, and drives the phase-0 command flags (chip select, row strobe, column strobe, write enable, all active high) toward a PHY. With each command it drives the address and bank buses. It also drives the clock-enable, termination and device-reset levels. After each step it waits a fixed number of cycles. It finishes by raising a done flag.

The memory family is a build-time parameter with these codes: 0 = SDR, 1 = DDR, 2 = LPDDR, 3 = DDR2, 4 = DDR3. Each wait time is also a parameter. CAS latency and CAS write latency are inputs, and the block assembles every mode-register word from them in logic. For the DDR3 family, an out-of-range latency raises an error flag and the sequencer stays idle.

Top module: `sdram_init_seq`

## Requirements
- R1: During and after reset, before any start, all command flags, `cke`, `odt`, `mem_rst_n`, `busy`, `done` and `cfg_err` are 0, and `addr` and `bank` are 0.
- R2: A start pulse in the idle state makes step 0 visible one clock edge later. For families 0–3, step 0 raises `cke`, `odt` and `mem_rst_n` together and waits `T_PWR`. For DDR3, step 0 raises `odt` and `mem_rst_n` with `cke` still low and waits `T_RST`. Step 1 then raises `cke` and waits `T_CKE`.
- R3: Commands are flag sets {cs,ras,cas,we}: precharge-all = 1101 with addr bit 10 set, mode load = 1111, auto-refresh = 1110, ZQ calibration = 1001 with addr bit 10 set. No flag is raised without cs, and no command is issued while `cke` or `mem_rst_n` is low.
- R4: A step with wait w is followed by the next step exactly w+1 cycles later, so a zero wait advances on the next cycle. The step lists are as follows. SDR: levels, precharge, mode+DLL-reset (T_MRD), precharge, refresh (T_RFC), refresh (T_RFC), mode (T_MRD). DDR inserts an extended-mode load of 0 to bank 1 after the first precharge, and LPDDR inserts the same load to bank 2.
- R5: The legacy mode word is cl<<4 plus log2 of the burst length (burst 1 for SDR, 4 otherwise). DDR2 adds write recovery 2 at bits 11:9. The first mode load also sets bit 8 (DLL reset). All mode loads go to bank 0.
- R6: DDR2 runs: levels, precharge, mode loads of 0 to banks 3, 2 and 1, mode+DLL-reset to bank 0, precharge, two refreshes, mode to bank 0, 0x380 to bank 1, and finally 0 to bank 1.
- R7: DDR3 MR0 (bank 0, wait T_MRD) has bits 1:0 = 00 (burst 8), bit 8 set and bits 11:9 = 100. Its CAS-latency code has bit 0 at bit 2 and bits 3:1 at bits 6:4. The code is 2·(cl−4) for cl 5..11 and 2·(cl−12)+1 for cl 12..14.
- R8: DDR3 loads MR2 = ((cwl−5)<<3)|(2<<9) to bank 2, then MR3 = 0 to bank 3, then MR1 = 0x0006 to bank 1, then MR0. ZQ calibration follows MR0 and waits T_ZQ.
- R9: Each command appears for exactly one cycle at its step. In every waiting cycle all command flags are 0 and `busy` is 1.
- R10: DDR3 only: a start with cl outside 5..14 or cwl outside 5..12 sets `cfg_err` and issues nothing, and the block stays idle. A later start with legal values clears `cfg_err` and runs.
- R11: A start while running or after completion is ignored. `done` stays high until reset, and the levels keep their final values (all high).
- R12: `done` rises and `busy` falls one cycle after the last step's wait has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cas_lat | input | 4 | CAS latency in cycles |
| cas_wr_lat | input | 4 | CAS write latency in cycles (DDR3 only) |
| cmd_cs | output | 1 | Chip-select flag, active high |
| cmd_ras | output | 1 | Row-strobe flag, active high |
| cmd_cas | output | 1 | Column-strobe flag, active high |
| cmd_we | output | 1 | Write-enable flag, active high |
| addr | output | ADDR_W | Address bus |
| bank | output | BA_W | Bank address |
| cke | output | 1 | Clock-enable level |
| odt | output | 1 | Termination level |
| mem_rst_n | output | 1 | Device reset level, active low |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence complete, sticky until reset |
| cfg_err | output | 1 | Illegal DDR3 latency at the last start attempt |

## Verification
The assertions check the rules that hold on every cycle. Flags never appear without chip select, and no command is issued with clock enable or device reset low. Every flag is traced to a step-issue event one cycle earlier. Done is sticky, the levels are frozen after completion, and an error leaves the block idle and silent. Only the bench's scenarios can show the exact step order, banks, mode-word bit layouts and wait spacing for each family and latency. The same holds for the ignored start pulses during and after a run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int FAM_SDR   = 0;
  localparam int FAM_DDR   = 1;
  localparam int FAM_LPDDR = 2;
  localparam int FAM_DDR2  = 3;
  localparam int FAM_DDR3  = 4;

  typedef enum logic [2:0] {K_CTRL, K_PRE, K_MRS, K_REF, K_ZQ} kind_e;
  typedef enum logic [2:0] {W_NONE, W_PWR, W_RST, W_CKE, W_MRD, W_RFC, W_ZQ} wsel_e;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;

  typedef struct packed {
    kind_e       kind;
    logic [15:0] addr;
    logic [2:0]  bank;
    logic        cke;
    logic        odt;
    logic        rst_n;
    wsel_e       wsel;
    logic        last;
  } step_t;

  // {cs, ras, cas, we}
  function automatic logic [3:0] kind_flags(kind_e k);
    case (k)
      K_PRE:   return 4'b1101;
      K_MRS:   return 4'b1111;
      K_REF:   return 4'b1110;
      K_ZQ:    return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic step_t mk(kind_e k, logic [15:0] a, logic [2:0] b, wsel_e w, logic lst);
    step_t s;
    s.kind  = k;
    s.addr  = a;
    s.bank  = b;
    s.cke   = 1'b1;
    s.odt   = 1'b1;
    s.rst_n = 1'b1;
    s.wsel  = w;
    s.last  = lst;
    return s;
  endfunction

  function automatic logic [15:0] legacy_mode(int fam, logic [3:0] cl, logic dll);
    logic [15:0] m;
    m = {8'd0, cl, 4'd0};
    if (fam != FAM_SDR) m[1:0] = 2'd2;
    if (fam == FAM_DDR2) m[11:9] = 3'd2;
    m[8] = dll;
    return m;
  endfunction

  function automatic logic [3:0] ddr3_cl_code(logic [3:0] cl);
    if (cl <= 4'd11) return {3'(cl - 4'd4), 1'b0};
    return {3'(cl - 4'd12), 1'b1};
  endfunction

  function automatic logic [15:0] ddr3_mr0(logic [3:0] cl);
    logic [15:0] m;
    logic [3:0]  c;
    c = ddr3_cl_code(cl);
    m = 16'd0;
    m[2]    = c[0];
    m[6:4]  = c[3:1];
    m[8]    = 1'b1;
    m[11:9] = 3'b100;
    return m;
  endfunction

  function automatic logic [15:0] ddr3_mr1(logic [1:0] ods, logic [2:0] rtt);
    logic [15:0] m;
    m = 16'd0;
    m[1] = ods[0];
    m[5] = ods[1];
    m[2] = rtt[0];
    m[6] = rtt[1];
    m[9] = rtt[2];
    return m;
  endfunction

  function automatic logic [15:0] ddr3_mr2(logic [3:0] cwl);
    logic [15:0] m;
    m = 16'd0;
    m[5:3]  = 3'(cwl - 4'd5);
    m[10:9] = 2'd2;
    return m;
  endfunction

  function automatic logic cfg_ok(int fam, logic [3:0] cl, logic [3:0] cwl);
    if (fam != FAM_DDR3) return 1'b1;
    return (cl >= 4'd5) && (cl <= 4'd14) && (cwl >= 4'd5) && (cwl <= 4'd12);
  endfunction

  function automatic step_t legacy_step(int fam, logic [3:0] idx, logic [3:0] cl);
    step_t      s;
    logic [3:0] j;
    s = mk(K_CTRL, 16'd0, 3'd0, W_PWR, 1'b0);
    if (fam == FAM_DDR2) begin
      case (idx)
        4'd0:    s = mk(K_CTRL, 16'd0, 3'd0, W_PWR, 1'b0);
        4'd1:    s = mk(K_PRE, 16'h0400, 3'd0, W_NONE, 1'b0);
        4'd2:    s = mk(K_MRS, 16'd0, 3'd3, W_NONE, 1'b0);
        4'd3:    s = mk(K_MRS, 16'd0, 3'd2, W_NONE, 1'b0);
        4'd4:    s = mk(K_MRS, 16'd0, 3'd1, W_NONE, 1'b0);
        4'd5:    s = mk(K_MRS, legacy_mode(fam, cl, 1'b1), 3'd0, W_MRD, 1'b0);
        4'd6:    s = mk(K_PRE, 16'h0400, 3'd0, W_NONE, 1'b0);
        4'd7:    s = mk(K_REF, 16'd0, 3'd0, W_RFC, 1'b0);
        4'd8:    s = mk(K_REF, 16'd0, 3'd0, W_RFC, 1'b0);
        4'd9:    s = mk(K_MRS, legacy_mode(fam, cl, 1'b0), 3'd0, W_MRD, 1'b0);
        4'd10:   s = mk(K_MRS, 16'h0380, 3'd1, W_NONE, 1'b0);
        default: s = mk(K_MRS, 16'd0, 3'd1, W_NONE, 1'b1);
      endcase
    end else if (fam != FAM_SDR && idx == 4'd2) begin
      s = mk(K_MRS, 16'd0, (fam == FAM_LPDDR) ? 3'd2 : 3'd1, W_NONE, 1'b0);
    end else begin
      j = (fam != FAM_SDR && idx > 4'd2) ? idx - 4'd1 : idx;
      case (j)
        4'd0:    s = mk(K_CTRL, 16'd0, 3'd0, W_PWR, 1'b0);
        4'd1:    s = mk(K_PRE, 16'h0400, 3'd0, W_NONE, 1'b0);
        4'd2:    s = mk(K_MRS, legacy_mode(fam, cl, 1'b1), 3'd0, W_MRD, 1'b0);
        4'd3:    s = mk(K_PRE, 16'h0400, 3'd0, W_NONE, 1'b0);
        4'd4:    s = mk(K_REF, 16'd0, 3'd0, W_RFC, 1'b0);
        4'd5:    s = mk(K_REF, 16'd0, 3'd0, W_RFC, 1'b0);
        default: s = mk(K_MRS, legacy_mode(fam, cl, 1'b0), 3'd0, W_MRD, 1'b1);
      endcase
    end
    return s;
  endfunction

  function automatic step_t ddr3_step(logic [3:0] idx, logic [3:0] cl, logic [3:0] cwl);
    step_t s;
    case (idx)
      4'd0: begin
        s = mk(K_CTRL, 16'd0, 3'd0, W_RST, 1'b0);
        s.cke = 1'b0;
      end
      4'd1:    s = mk(K_CTRL, 16'd0, 3'd0, W_CKE, 1'b0);
      4'd2:    s = mk(K_MRS, ddr3_mr2(cwl), 3'd2, W_NONE, 1'b0);
      4'd3:    s = mk(K_MRS, 16'd0, 3'd3, W_NONE, 1'b0);
      4'd4:    s = mk(K_MRS, ddr3_mr1(2'd1, 3'd1), 3'd1, W_NONE, 1'b0);
      4'd5:    s = mk(K_MRS, ddr3_mr0(cl), 3'd0, W_MRD, 1'b0);
      default: s = mk(K_ZQ, 16'h0400, 3'd0, W_ZQ, 1'b1);
    endcase
    return s;
  endfunction

  function automatic step_t step_of(int fam, logic [3:0] idx, logic [3:0] cl, logic [3:0] cwl);
    if (fam == FAM_DDR3) return ddr3_step(idx, cl, cwl);
    return legacy_step(fam, idx, cl);
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_init_rom.sv
module sdram_init_rom
  import sdram_init_pkg::*;
#(
  parameter int FAMILY = FAM_DDR3,
  parameter int ADDR_W = 16,
  parameter int BA_W   = 3,
  parameter int T_PWR  = 20000,
  parameter int T_RST  = 50000,
  parameter int T_CKE  = 10000,
  parameter int T_MRD  = 200,
  parameter int T_RFC  = 4,
  parameter int T_ZQ   = 200,
  parameter int WAIT_W = 16
) (
  input  logic [3:0]        idx,
  input  logic [3:0]        cl,
  input  logic [3:0]        cwl,
  output kind_e             kind,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   bank,
  output logic [2:0]        levels,
  output logic              last,
  output logic [WAIT_W-1:0] wait_cycles
);
  step_t s;

  assign s      = step_of(FAMILY, idx, cl, cwl);
  assign kind   = s.kind;
  assign addr   = s.addr[ADDR_W-1:0];
  assign bank   = s.bank[BA_W-1:0];
  assign levels = {s.cke, s.odt, s.rst_n};
  assign last   = s.last;

  always_comb begin
    case (s.wsel)
      W_PWR:   wait_cycles = WAIT_W'(T_PWR);
      W_RST:   wait_cycles = WAIT_W'(T_RST);
      W_CKE:   wait_cycles = WAIT_W'(T_CKE);
      W_MRD:   wait_cycles = WAIT_W'(T_MRD);
      W_RFC:   wait_cycles = WAIT_W'(T_RFC);
      W_ZQ:    wait_cycles = WAIT_W'(T_ZQ);
      default: wait_cycles = '0;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int FAMILY = FAM_DDR3,
  parameter int ADDR_W = 16,
  parameter int BA_W   = 3,
  parameter int T_PWR  = 20000,
  parameter int T_RST  = 50000,
  parameter int T_CKE  = 10000,
  parameter int T_MRD  = 200,
  parameter int T_RFC  = 4,
  parameter int T_ZQ   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cas_lat,
  input  logic [3:0]        cas_wr_lat,
  output logic              cmd_cs,
  output logic              cmd_ras,
  output logic              cmd_cas,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   bank,
  output logic              cke,
  output logic              odt,
  output logic              mem_rst_n,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  localparam int TM_A   = (T_PWR > T_RST) ? T_PWR : T_RST;
  localparam int TM_B   = (T_CKE > T_MRD) ? T_CKE : T_MRD;
  localparam int TM_C   = (T_RFC > T_ZQ)  ? T_RFC : T_ZQ;
  localparam int TM_AB  = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int T_MAX  = (TM_AB > TM_C) ? TM_AB : TM_C;
  localparam int WAIT_W = $clog2(T_MAX + 1);

  state_e            state;
  logic [3:0]        idx;
  logic              cur_last;
  logic [3:0]        rom_idx;
  kind_e             rom_kind;
  logic [ADDR_W-1:0] rom_addr;
  logic [BA_W-1:0]   rom_bank;
  logic [2:0]        rom_lv;
  logic              rom_last;
  logic [WAIT_W-1:0] rom_wait;
  logic              expired;

  // named internal events
  logic cfg_good;
  logic launch;
  logic advance;
  logic finish;
  logic step_issue;

  assign cfg_good   = cfg_ok(FAMILY, cas_lat, cas_wr_lat);
  assign launch     = (state == S_IDLE) && start && cfg_good;
  assign advance    = (state == S_RUN) && expired && !cur_last;
  assign finish     = (state == S_RUN) && expired && cur_last;
  assign step_issue = launch || advance;
  assign rom_idx    = (state == S_IDLE) ? 4'd0 : idx + 4'd1;
  assign busy       = (state == S_RUN);

  sdram_init_rom #(
    .FAMILY(FAMILY), .ADDR_W(ADDR_W), .BA_W(BA_W),
    .T_PWR(T_PWR), .T_RST(T_RST), .T_CKE(T_CKE),
    .T_MRD(T_MRD), .T_RFC(T_RFC), .T_ZQ(T_ZQ), .WAIT_W(WAIT_W)
  ) u_rom (
    .idx(rom_idx), .cl(cas_lat), .cwl(cas_wr_lat),
    .kind(rom_kind), .addr(rom_addr), .bank(rom_bank),
    .levels(rom_lv), .last(rom_last), .wait_cycles(rom_wait)
  );

  sdram_init_timer #(.W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(step_issue),
    .load_val(rom_wait), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= 4'd0;
      cur_last  <= 1'b0;
      cmd_cs    <= 1'b0;
      cmd_ras   <= 1'b0;
      cmd_cas   <= 1'b0;
      cmd_we    <= 1'b0;
      addr      <= '0;
      bank      <= '0;
      cke       <= 1'b0;
      odt       <= 1'b0;
      mem_rst_n <= 1'b0;
      done      <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      {cmd_cs, cmd_ras, cmd_cas, cmd_we} <= 4'b0000;
      if (state == S_IDLE && start) cfg_err <= !cfg_good;
      if (step_issue) begin
        idx      <= rom_idx;
        cur_last <= rom_last;
        if (rom_kind == K_CTRL) begin
          {cke, odt, mem_rst_n} <= rom_lv;
          addr <= '0;
          bank <= '0;
        end else begin
          {cmd_cs, cmd_ras, cmd_cas, cmd_we} <= kind_flags(rom_kind);
          addr <= rom_addr;
          bank <= rom_bank;
        end
      end
      case (state)
        S_IDLE:  if (launch) state <= S_RUN;
        S_RUN:   if (finish) begin
                   state <= S_DONE;
                   done  <= 1'b1;
                 end
        default: state <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_cs,
  input logic cmd_ras,
  input logic cmd_cas,
  input logic cmd_we,
  input logic cke,
  input logic odt,
  input logic mem_rst_n,
  input logic busy,
  input logic done,
  input logic cfg_err,
  input logic step_issue
);
  a_r3_flags_need_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ras || cmd_cas || cmd_we) |-> cmd_cs);

  a_r3_cmd_needs_levels: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs |-> (cke && mem_rst_n));

  a_r9_cmd_from_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs |-> $past(step_issue));

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r11_levels_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable({cke, odt, mem_rst_n}));

  a_r11_no_issue_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !step_issue);

  a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cmd_cs));

  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!busy && !cmd_cs && !done));

  a_r2_reset_level_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(mem_rst_n));
endmodule

bind sdram_init_seq sdram_init_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_cs(cmd_cs), .cmd_ras(cmd_ras), .cmd_cas(cmd_cas), .cmd_we(cmd_we),
  .cke(cke), .odt(odt), .mem_rst_n(mem_rst_n),
  .busy(busy), .done(done), .cfg_err(cfg_err),
  .step_issue(step_issue)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
  localparam int P_PWR = 41, P_RST = 57, P_CKE = 23, P_MRD = 9, P_RFC = 3, P_ZQ = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] start_v = '0;
  logic [3:0] cl_in = 4'd5;
  logic [3:0] cwl_in = 4'd5;
  logic [4:0] cs_v, ras_v, cas_v, we_v, cke_v, odt_v, mrst_v, busy_v, done_v, err_v;
  logic [15:0] addr_v [5];
  logic [2:0]  ba_v [5];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < 5; g++) begin : g_fam
    sdram_init_seq #(
      .FAMILY(g), .ADDR_W(16), .BA_W(3),
      .T_PWR(P_PWR), .T_RST(P_RST), .T_CKE(P_CKE),
      .T_MRD(P_MRD), .T_RFC(P_RFC), .T_ZQ(P_ZQ)
    ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start_v[g]),
      .cas_lat(cl_in), .cas_wr_lat(cwl_in),
      .cmd_cs(cs_v[g]), .cmd_ras(ras_v[g]), .cmd_cas(cas_v[g]), .cmd_we(we_v[g]),
      .addr(addr_v[g]), .bank(ba_v[g]),
      .cke(cke_v[g]), .odt(odt_v[g]), .mem_rst_n(mrst_v[g]),
      .busy(busy_v[g]), .done(done_v[g]), .cfg_err(err_v[g])
    );
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int n_steps(int f);
    case (f)
      0: return 7;
      3: return 12;
      4: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic int ddr3_code(int cl);
    case (cl)
      5: return 2;   6: return 4;   7: return 6;   8: return 8;
      9: return 10;  10: return 12; 11: return 14; 12: return 1;
      13: return 3;  default: return 5;
    endcase
  endfunction

  // expected step: flags {cs,ras,cas,we}, levels {cke,odt,rst_n}, bank, addr, wait, tag
  task automatic exp_step(input int f, input int k, input int cl, input int cwl,
                          output logic [3:0] fl, output logic [2:0] lv, output int ba,
                          output int ad, output int wt, output string tag);
    int base, kk, c;
    fl = 4'b1111; lv = 3'b111; ba = 0; ad = 0; wt = 0; tag = "R4";
    base = cl * 16 + ((f == 0) ? 0 : 2) + ((f == 3) ? 1024 : 0);
    if (f == 4) begin
      case (k)
        0: begin fl = 0; lv = 3'b011; wt = P_RST; tag = "R2"; end
        1: begin fl = 0; wt = P_CKE; tag = "R2"; end
        2: begin ba = 2; ad = (cwl - 5) * 8 + 1024; tag = "R8"; end
        3: begin ba = 3; tag = "R8"; end
        4: begin ba = 1; ad = 6; tag = "R8"; end
        5: begin c = ddr3_code(cl); ad = 'h900 + (c % 2) * 4 + (c / 2) * 16; wt = P_MRD; tag = "R7"; end
        default: begin fl = 4'b1001; ad = 'h400; wt = P_ZQ; tag = "R3"; end
      endcase
    end else if (f == 3) begin
      case (k)
        0: begin fl = 0; wt = P_PWR; tag = "R2"; end
        1, 6: begin fl = 4'b1101; ad = 'h400; tag = "R3"; end
        2: begin ba = 3; tag = "R6"; end
        3: begin ba = 2; tag = "R6"; end
        4: begin ba = 1; tag = "R6"; end
        5: begin ad = base + 256; wt = P_MRD; tag = "R5"; end
        7, 8: begin fl = 4'b1110; wt = P_RFC; tag = "R3"; end
        9: begin ad = base; wt = P_MRD; tag = "R5"; end
        10: begin ba = 1; ad = 'h380; tag = "R6"; end
        default: begin ba = 1; tag = "R6"; end
      endcase
    end else begin
      if (f != 0 && k == 2) begin
        ba = (f == 2) ? 2 : 1; tag = "R4";
      end else begin
        kk = (f != 0 && k > 2) ? k - 1 : k;
        case (kk)
          0: begin fl = 0; wt = P_PWR; tag = "R2"; end
          1, 3: begin fl = 4'b1101; ad = 'h400; tag = "R3"; end
          2: begin ad = base + 256; wt = P_MRD; tag = "R5"; end
          4, 5: begin fl = 4'b1110; wt = P_RFC; tag = "R3"; end
          default: begin ad = base; wt = P_MRD; tag = "R5"; end
        endcase
      end
    end
  endtask

  task automatic run_seq(int f, int cl, int cwl);
    logic [3:0] fl; logic [2:0] lv; int ba, ad, wt, n; string tag;
    logic [3:0] afl; logic [2:0] alv; bit gap_ok, quiet;
    n = n_steps(f);
    start_v[f] = 1'b1;
    @(negedge clk);
    start_v[f] = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      exp_step(f, k, cl, cwl, fl, lv, ba, ad, wt, tag);
      afl = {cs_v[f], ras_v[f], cas_v[f], we_v[f]};
      alv = {cke_v[f], odt_v[f], mrst_v[f]};
      check(afl == fl && alv == lv && busy_v[f] && !err_v[f], tag, $sformatf("fam%0d step%0d flags/levels", f, k),
            {afl, alv, busy_v[f]}, {fl, lv, 1'b1});
      if (fl != 0)
        check(addr_v[f] == 16'(ad) && ba_v[f] == 3'(ba), tag, $sformatf("fam%0d step%0d addr/bank (R4)", f, k),
              {addr_v[f], 1'b0, ba_v[f]}, {16'(ad), 1'b0, 3'(ba)});
      gap_ok = 1;
      for (int c = 0; c < wt; c++) begin
        @(negedge clk);
        if ({cs_v[f], ras_v[f], cas_v[f], we_v[f]} != 0 || !busy_v[f]) gap_ok = 0;
        if (k == 0 && c == 0) start_v[f] = 1'b1;   // R11 start while running
        if (k == 0 && c == 1) start_v[f] = 1'b0;
      end
      if (wt > 0) check(gap_ok, "R9", $sformatf("fam%0d step%0d wait quiet", f, k), {63'd0, gap_ok}, 64'd1);
    end
    @(negedge clk);
    check(done_v[f] && !busy_v[f] && {cke_v[f], odt_v[f], mrst_v[f]} == 3'b111, "R12",
          $sformatf("fam%0d done timing", f), {done_v[f], busy_v[f]}, 2'b10);
    start_v[f] = 1'b1;
    @(negedge clk);
    start_v[f] = 1'b0;
    quiet = 1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (cs_v[f] || busy_v[f] || !done_v[f] || {cke_v[f], odt_v[f], mrst_v[f]} != 3'b111) quiet = 0;
    end
    check(quiet, "R11", $sformatf("fam%0d start after done ignored", f), {63'd0, quiet}, 64'd1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_all(int cl, int cwl, bit with_ddr3);
    cl_in = 4'(cl); cwl_in = 4'(cwl);
    do_reset();
    fork
      run_seq(0, cl, cwl);
      run_seq(1, cl, cwl);
      run_seq(2, cl, cwl);
      run_seq(3, cl, cwl);
      if (with_ddr3) run_seq(4, cl, cwl);
    join
  endtask

  task automatic err_try(int cl, int cwl);
    bit quiet;
    cl_in = 4'(cl); cwl_in = 4'(cwl);
    start_v[4] = 1'b1;
    @(negedge clk);
    start_v[4] = 1'b0;
    check(err_v[4] && !busy_v[4], "R10", $sformatf("ddr3 bad cl=%0d cwl=%0d flags error", cl, cwl),
          {err_v[4], busy_v[4]}, 2'b10);
    quiet = 1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (cs_v[4] || busy_v[4] || done_v[4] || cke_v[4] || mrst_v[4]) quiet = 0;
    end
    check(quiet, "R10", "ddr3 stays idle after error", {63'd0, quiet}, 64'd1);
  endtask

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    check({cs_v, ras_v, cas_v, we_v, cke_v, odt_v, mrst_v, busy_v, done_v, err_v} == 0, "R1",
          "outputs in reset", 64'({cs_v, cke_v, mrst_v, done_v}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({cs_v, ras_v, cas_v, we_v, cke_v, odt_v, mrst_v, busy_v, done_v, err_v} == 0, "R1",
          "outputs idle after reset", 64'({cs_v, cke_v, mrst_v, busy_v}), 64'd0);
    for (int g = 0; g < 5; g++)
      check(addr_v[g] == 0 && ba_v[g] == 0, "R1", $sformatf("fam%0d addr/bank reset", g),
            {addr_v[g], ba_v[g]}, 64'd0);
    // directed corners
    run_all(5, 5, 1);
    run_all(14, 12, 1);
    run_all(11, 8, 1);
    run_all(12, 6, 1);
    run_all(3, 5, 0);
    // random
    for (int r = 0; r < 4; r++) begin
      int cl, cwl;
      cl = 5 + int'($urandom_range(9));
      cwl = 5 + int'($urandom_range(7));
      run_all(cl, cwl, 1);
    end
    // error handling
    do_reset();
    err_try(4, 7);
    err_try(9, 13);
    err_try(15, 5);
    cl_in = 4'd9; cwl_in = 4'd7;
    run_seq(4, 9, 7);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule